// File: doc/BRIEF.md
# Pocket Calculator Sequencer

This block is the control core of a four-function integer calculator that behaves like a pocket calculator. Upstream logic supplies decoded key presses as a 4-bit code with a one-cycle valid strobe. The block builds the operand one decimal digit at a time. When the next operator or the equals key arrives, it applies the operator that was stored earlier. It then presents a binary value of 0 to 999 for a downstream decimal display path.

Add, subtract and multiply settle in one cycle. Division goes to an internal divider that works by repeated subtraction. The divider takes a variable number of cycles. The sequencer starts it with a one-cycle pulse and waits in a dedicated state until it reports completion. Key presses that arrive while a computation is in progress are dropped.

Top module: `calc_ctrl`

## Requirements
- R1: After reset the display value is 0, the running result is 0, no operator is pending and no operand digit has been entered.
- R2: Codes 0x0 to 0x9 are digits. In the idle state a digit sets the operand to operand*10 + digit, but only while the operand is below 100; otherwise the operand is unchanged. On the next clock edge the display shows the operand.
- R3: The operator codes are 0xA add, 0xB subtract, 0xD multiply and 0xE divide. An operator key applies the stored operator to the running result and the operand, then stores the new operator. For add, subtract and multiply, the display shows the new result on the third clock edge after the key strobe.
- R4: When no operator is stored and a digit has been entered, an operator or equals key copies the operand into the running result.
- R5: When no digit has been entered since the last result was shown, an operator or equals key leaves the running result unchanged and replaces the stored operator.
- R6: Equals (0xF) applies the stored operator, shows the result and leaves no operator stored. Every result shown empties the operand, so the next digit starts a fresh entry.
- R7: Clear (0xC) sets the running result, the operand and the display to 0 and leaves no operator stored.
- R8: Division uses a start/done divider that subtracts repeatedly, giving the truncated quotient. A negative running result is divided as 0.
- R9: Division by a zero operand gives 0 without starting the divider.
- R10: The display shows the running result clamped to 0..999; negative results show 0.
- R11: A key strobe that arrives while the block is not idle (computing, dividing or showing) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-cycle strobe marking a decoded key |
| key_code | input | 4 | Decoded key code |
| disp_value | output | 10 | Binary value for the display, 0..999 |

## Verification
The assertions assume that `key_valid` lasts one cycle per press and that `key_code` holds a defined value whenever the strobe is high. The digit and clear properties trigger only on strobes seen in the idle state, so they do not depend on how often keys arrive. The stimulus pulses the strobe for a single cycle and then waits long enough for the longest division (999 divided by 1) to finish. The one exception is a deliberate strobe during a division, used to show that it is dropped.

// File: rtl/calc_pkg.sv
package calc_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_DIV
    } calc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DIV,
        ST_SHOW
    } calc_state_e;

    localparam logic [3:0] KEY_ADD = 4'hA;
    localparam logic [3:0] KEY_SUB = 4'hB;
    localparam logic [3:0] KEY_CLR = 4'hC;
    localparam logic [3:0] KEY_MUL = 4'hD;
    localparam logic [3:0] KEY_DIV = 4'hE;
    localparam logic [3:0] KEY_EQ  = 4'hF;

    function automatic logic key_is_digit(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

    function automatic calc_op_e key_to_op(input logic [3:0] code);
        case (code)
            KEY_ADD: return OP_ADD;
            KEY_SUB: return OP_SUB;
            KEY_MUL: return OP_MUL;
            KEY_DIV: return OP_DIV;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/calc_entry.sv
// Operand accumulator: builds a decimal operand digit by digit with a cap.
module calc_entry #(
    parameter int ARG_W = 10,
    parameter int CAP   = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [3:0]       digit,
    output logic [ARG_W-1:0] arg,
    output logic [ARG_W-1:0] arg_nx,
    output logic             have
);

    always_comb begin
        arg_nx = arg;
        if (push && arg < ARG_W'(CAP))
            arg_nx = arg * ARG_W'(10) + ARG_W'(digit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            arg  <= '0;
            have <= 1'b0;
        end else if (push) begin
            arg  <= arg_nx;
            have <= 1'b1;
        end
    end

endmodule

// File: rtl/calc_alu.sv
// Single-cycle add, subtract, multiply on the running result.
module calc_alu
    import calc_pkg::*;
#(
    parameter int RES_W = 24,
    parameter int ARG_W = 10
) (
    input  calc_op_e                 op,
    input  logic signed [RES_W-1:0]  acc,
    input  logic        [ARG_W-1:0]  arg,
    output logic signed [RES_W-1:0]  res
);

    logic signed [RES_W-1:0] argx;

    always_comb begin
        argx = signed'({{(RES_W-ARG_W){1'b0}}, arg});
        case (op)
            OP_ADD:  res = acc + argx;
            OP_SUB:  res = acc - argx;
            OP_MUL:  res = acc * argx;
            OP_NONE: res = argx;
            default: res = acc;
        endcase
    end

endmodule

// File: rtl/calc_divider.sv
// Repeated-subtraction divider with start pulse and one-cycle done pulse.
module calc_divider #(
    parameter int N_W = 23,
    parameter int D_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           done,
    output logic [N_W-1:0] quo
);

    logic [N_W-1:0] rem;
    logic [N_W-1:0] dwide;
    logic           busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            dwide <= '0;
            quo   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem   <= num;
            dwide <= N_W'(den);
            quo   <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (rem >= dwide) begin
                rem <= rem - dwide;
                quo <= quo + 1'b1;
            end else begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/calc_ctrl.sv
module calc_ctrl
    import calc_pkg::*;
#(
    parameter int NDIG  = 3,
    parameter int RES_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_valid,
    input  logic [3:0] key_code,
    output logic [9:0] disp_value
);

    localparam int DISP_MAX = 10**NDIG - 1;
    localparam int ARG_CAP  = 10**(NDIG-1);
    localparam int DISP_W   = $clog2(DISP_MAX + 1);
    localparam int ARG_W    = DISP_W;
    localparam int N_W      = RES_W - 1;
    localparam logic signed [RES_W-1:0] DISP_MAX_S = RES_W'(DISP_MAX);

    calc_state_e             state;
    calc_op_e                op_q;
    calc_op_e                op_nx;
    logic signed [RES_W-1:0] acc;
    logic signed [RES_W-1:0] alu_res;
    logic        [DISP_W-1:0] disp;
    logic        [DISP_W-1:0] disp_clamp;
    logic        [ARG_W-1:0] arg;
    logic        [ARG_W-1:0] arg_nx;
    logic                    have;
    logic                    key_act;
    logic                    digit_push;
    logic                    clr_key;
    logic                    op_key;
    logic                    entry_clear;
    logic                    div_start;
    logic                    div_done;
    logic        [N_W-1:0]   div_num;
    logic        [N_W-1:0]   div_quo;

    assign key_act     = key_valid && (state == ST_IDLE);
    assign digit_push  = key_act && key_is_digit(key_code);
    assign clr_key     = key_act && (key_code == KEY_CLR);
    assign op_key      = key_act && !key_is_digit(key_code) && (key_code != KEY_CLR);
    assign entry_clear = clr_key || (state == ST_SHOW);
    assign div_num     = acc[RES_W-1] ? '0 : acc[N_W-1:0];

    always_comb begin
        if (acc[RES_W-1])
            disp_clamp = '0;
        else if (acc > DISP_MAX_S)
            disp_clamp = DISP_W'(DISP_MAX);
        else
            disp_clamp = acc[DISP_W-1:0];
    end

    calc_entry #(.ARG_W(ARG_W), .CAP(ARG_CAP)) u_entry (
        .clk    (clk),
        .rst    (rst),
        .clear  (entry_clear),
        .push   (digit_push),
        .digit  (key_code),
        .arg    (arg),
        .arg_nx (arg_nx),
        .have   (have)
    );

    calc_alu #(.RES_W(RES_W), .ARG_W(ARG_W)) u_alu (
        .op  (op_q),
        .acc (acc),
        .arg (arg),
        .res (alu_res)
    );

    calc_divider #(.N_W(N_W), .D_W(ARG_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (arg),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_NONE;
            op_nx     <= OP_NONE;
            acc       <= '0;
            disp      <= '0;
            div_start <= 1'b0;
        end else begin
            div_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (clr_key) begin
                        acc  <= '0;
                        op_q <= OP_NONE;
                        disp <= '0;
                    end else if (digit_push) begin
                        disp <= arg_nx;
                    end else if (op_key) begin
                        op_nx <= key_to_op(key_code);
                        state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (!have) begin
                        state <= ST_SHOW;
                    end else if (op_q == OP_DIV) begin
                        if (arg == '0) begin
                            acc   <= '0;
                            state <= ST_SHOW;
                        end else begin
                            div_start <= 1'b1;
                            state     <= ST_DIV;
                        end
                    end else begin
                        acc   <= alu_res;
                        state <= ST_SHOW;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        acc   <= signed'({1'b0, div_quo});
                        state <= ST_SHOW;
                    end
                end
                ST_SHOW: begin
                    disp  <= disp_clamp;
                    op_q  <= op_nx;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign disp_value = 10'(disp);

endmodule

// File: rtl/calc_ctrl_chk.sv
module calc_ctrl_chk
    import calc_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_valid,
    input  logic [3:0]  key_code,
    input  logic [9:0]  disp_value,
    input  calc_state_e state,
    input  logic [9:0]  arg,
    input  logic        div_start,
    input  logic        div_done
);

    localparam int DISP_MAX = 10**NDIG - 1;
    localparam int ARG_CAP  = 10**(NDIG-1);

    logic idle_key;
    assign idle_key = key_valid && (state == ST_IDLE);

    AST_DISP_RANGE: assert property (@(posedge clk) disable iff (rst)
        disp_value <= 10'(DISP_MAX)); // R10

    AST_ARG_RANGE: assert property (@(posedge clk) disable iff (rst)
        arg <= 10'(DISP_MAX)); // R2

    AST_DIGIT_ACCUM: assert property (@(posedge clk) disable iff (rst)
        (idle_key && key_code <= 4'd9 && arg < 10'(ARG_CAP))
        |=> arg == 10'($past(arg) * 10'd10 + 10'($past(key_code)))); // R2

    AST_DIGIT_CAP: assert property (@(posedge clk) disable iff (rst)
        (idle_key && key_code <= 4'd9 && arg >= 10'(ARG_CAP)) |=> $stable(arg)); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (idle_key && key_code == KEY_CLR) |=> (disp_value == 10'd0 && arg == 10'd0)); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CALC || state == ST_DIV) |=> $stable(arg)); // R11

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        div_start |=> !div_start); // R8

    AST_DIV_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIV && !div_done) |=> state == ST_DIV); // R8

endmodule

bind calc_ctrl calc_ctrl_chk #(.NDIG(NDIG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .key_valid  (key_valid),
    .key_code   (key_code),
    .disp_value (disp_value),
    .state      (state),
    .arg        (arg),
    .div_start  (div_start),
    .div_done   (div_done)
);

// File: tb/tb_calc_ctrl.sv
module tb_calc_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'h0;
    logic [9:0] disp_value;

    int checks = 0;
    int failures = 0;

    localparam int OP_WAIT = 1100;
    localparam int NV = 60;

    // {requirement, key code, expected display}
    localparam logic [17:0] VEC [NV] = '{
        // R2 R4 R6: 123 + 45 =
        {4'd2, 4'h1, 10'd1}, {4'd2, 4'h2, 10'd12}, {4'd2, 4'h3, 10'd123},
        {4'd4, 4'hA, 10'd123}, {4'd2, 4'h4, 10'd4}, {4'd2, 4'h5, 10'd45},
        {4'd6, 4'hF, 10'd168},
        // R6 R3: fresh 7 * 2 * 3 =
        {4'd6, 4'h7, 10'd7}, {4'd4, 4'hD, 10'd7}, {4'd2, 4'h2, 10'd2},
        {4'd3, 4'hD, 10'd14}, {4'd2, 4'h3, 10'd3}, {4'd3, 4'hF, 10'd42},
        // R7 R2 R10: 999 (cap) * 2 = clamps
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h9, 10'd9}, {4'd2, 4'h9, 10'd99},
        {4'd2, 4'h9, 10'd999}, {4'd2, 4'h9, 10'd999}, {4'd3, 4'hD, 10'd999},
        {4'd2, 4'h2, 10'd2}, {4'd10, 4'hF, 10'd999},
        // R10 R5: 5 - 8 = (-3) then + 10 =
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h5, 10'd5}, {4'd3, 4'hB, 10'd5},
        {4'd2, 4'h8, 10'd8}, {4'd10, 4'hF, 10'd0}, {4'd5, 4'hA, 10'd0},
        {4'd2, 4'h1, 10'd1}, {4'd2, 4'h0, 10'd10}, {4'd5, 4'hF, 10'd7},
        // R8: 100 / 7 =
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h1, 10'd1}, {4'd2, 4'h0, 10'd10},
        {4'd2, 4'h0, 10'd100}, {4'd3, 4'hE, 10'd100}, {4'd2, 4'h7, 10'd7},
        {4'd8, 4'hF, 10'd14},
        // R5 R9: / 0 =
        {4'd5, 4'hE, 10'd14}, {4'd2, 4'h0, 10'd0}, {4'd9, 4'hF, 10'd0},
        // R5: operator replaced without digit: 25 + + - 5 =
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h2, 10'd2}, {4'd2, 4'h5, 10'd25},
        {4'd4, 4'hA, 10'd25}, {4'd5, 4'hA, 10'd25}, {4'd5, 4'hB, 10'd25},
        {4'd2, 4'h5, 10'd5}, {4'd5, 4'hF, 10'd20},
        // R4: leading zeros then equals with no operator
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h0, 10'd0}, {4'd2, 4'h0, 10'd0},
        {4'd2, 4'h7, 10'd7}, {4'd4, 4'hF, 10'd7},
        // R8: negative dividend (3 - 9) / 2 =
        {4'd7, 4'hC, 10'd0}, {4'd2, 4'h3, 10'd3}, {4'd3, 4'hB, 10'd3},
        {4'd2, 4'h9, 10'd9}, {4'd10, 4'hE, 10'd0}, {4'd2, 4'h2, 10'd2},
        {4'd8, 4'hF, 10'd0}
    };

    calc_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .key_valid  (key_valid),
        .key_code   (key_code),
        .disp_value (disp_value)
    );

    always #2 clk = ~clk;

    task automatic check(input int req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL R%0d actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic press(input logic [3:0] code);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = code;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic press_wait(input logic [3:0] code);
        press(code);
        if (code <= 4'd9 || code == 4'hC)
            repeat (1) @(negedge clk);
        else
            repeat (OP_WAIT) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, int'(disp_value), 0); // R1 reset state
        // R1: no operator pending, no digit: equals keeps 0
        press_wait(4'hF);
        check(1, int'(disp_value), 0);

        for (int i = 0; i < NV; i++) begin
            press_wait(VEC[i][13:10]);
            check(int'(VEC[i][17:14]), int'(disp_value), int'(VEC[i][9:0]));
        end

        // R3 latency: 4 + 5 = shows 9 on the third edge after the strobe
        press_wait(4'hC);
        press(4'h4);
        check(2, int'(disp_value), 4); // R2 digit shown after one edge
        press_wait(4'hA);
        press_wait(4'h5);
        press(4'hF);
        @(negedge clk);
        check(3, int'(disp_value), 5);
        @(negedge clk);
        check(3, int'(disp_value), 9);

        // R11: subtract key during a long division is dropped
        press_wait(4'hC);
        press_wait(4'h9);
        press_wait(4'h9);
        press_wait(4'h9);
        press_wait(4'hE);
        press_wait(4'h1);
        press(4'hF);
        repeat (3) @(negedge clk);
        press(4'hB);
        repeat (OP_WAIT) @(negedge clk);
        check(8, int'(disp_value), 999); // R8 999 / 1
        press_wait(4'h1);
        press_wait(4'hF);
        check(11, int'(disp_value), 1); // R11 no operator was taken

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule